// File: doc/BRIEF.md
# Keyed Flash Write-Protection Controller

This block sits beside a flash array and decides, for every access, whether a page may be programmed or erased. It also decides whether the array may be read out through the debug port. It combines two 32-bit protection words, and in both of them a cleared bit means "protected". The first is a volatile word that software writes directly and that returns to all-ones on every system reset. The second is a persistent word. Software first loads a staging copy, then issues a save command, and the saved value only starts to govern accesses after the next system reset.

Changes to the persistent word are guarded by a 32-bit key. The key is assembled from two 16-bit key registers. While the key is still erased, the first save is accepted and the key entered with it is stored. From then on, every save must present that same key. One special key value locks the persistent word for good. A mass-erase input restores the key and all persistent protection to the erased state. The persistent registers survive the ordinary reset and are cleared only by mass erase.

Top module: `flash_guard`

## Requirements
- R1: After a system reset the volatile word is all-ones. A write with `reg_sel`=0 loads `reg_wdata` into it, and the new value governs decisions from the next cycle on.
- R2: Page `p` (512-byte pages, four pages per group) is writable only when bit `p/4` of the effective mask is 1. Pages 124 and above (group 31 onward) are never writable.
- R3: The effective mask is the bitwise AND of the active persistent word and the volatile word, so either word alone can protect a group.
- R4: `rd_allow` is 1 only while `dbg_rd` is 1 and bit 31 of the effective mask is 1.
- R5: A value written with `reg_sel`=1 (staging), even after a successful save, does not change any decision until a system reset follows the save.
- R6: The save command (code 0x0C) fails and changes nothing unless the mode register, written with `reg_sel`=2, last had bit 6 = 1 and bit 5 = 0.
- R7: While the stored key is erased (0xFFFFFFFF), a save is accepted without a key comparison. The entered key, with bits 31:16 from `reg_sel`=3 and bits 15:0 from `reg_sel`=4, becomes the stored key.
- R8: Once a key is stored, a save whose entered key differs fails and leaves the saved word unchanged. A save with the matching key passes.
- R9: Once the stored key is 0xDEADDEAD, every save fails, including one that presents that same key.
- R10: `mass_erase` returns the stored key, the saved word and the active word to all-ones at once, which removes persistent protection and any permanent lock.
- R11: For each `cmd_valid` cycle, `cmd_done` pulses high in the following cycle, with `cmd_pass` giving the outcome. Any code other than 0x0C fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset; loads the saved word into the active word |
| mass_erase | input | 1 | Synchronous clear of all persistent state to the erased value |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 volatile, 1 staging, 2 mode, 3 key high, 4 key low |
| reg_wdata | input | 32 | Register write data |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code |
| query_page | input | 7 | Page number being checked |
| dbg_rd | input | 1 | Debug-port read request |
| wr_allow | output | 1 | Queried page may be written |
| rd_allow | output | 1 | Debug read is granted |
| cmd_done | output | 1 | Command result valid |
| cmd_pass | output | 1 | Command succeeded |

## Verification
The bench probes the deferred activation by checking a page after the save and before the reset, and again after the reset. A design that applied the save at once, or never applied it, fails one of those checks. It probes the key gate with a wrong key, the matching key, and a save attempted in the forbidden mode. A design that skipped the comparison, or failed to keep the saved word unchanged on failure, would open or close the wrong pages. For the permanent key it retries with the identical key, which a plain equality gate would wrongly accept. It then applies mass erase to show that the lock and the pages are both released. It also places the volatile and persistent words on different groups, which catches an OR in place of an AND. Pages at the top of the range are checked too, which catches a wrong group index.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

    localparam int WORD_W          = 32;
    localparam int HALF_W          = 16;
    localparam int READ_BIT        = 31;
    localparam int NUM_GROUPS_DEF  = 31;
    localparam int PAGES_GRP_DEF   = 4;
    localparam int MODE_KEYEN_BIT  = 6;
    localparam int MODE_KEYBLK_BIT = 5;

    localparam logic [WORD_W-1:0] KEY_ERASED    = '1;
    localparam logic [WORD_W-1:0] KEY_PERMANENT = 32'hDEAD_DEAD;
    localparam logic [7:0]        CMD_SAVE      = 8'h0C;

    typedef enum logic [2:0] {
        SEL_VMASK = 3'd0,
        SEL_STAGE = 3'd1,
        SEL_MODE  = 3'd2,
        SEL_KEYHI = 3'd3,
        SEL_KEYLO = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic keyen;
        logic keyblk;
    } mode_t;

    typedef struct packed {
        logic [WORD_W-1:0] vmask;
        logic [WORD_W-1:0] stage;
        mode_t             mode;
        logic [HALF_W-1:0] key_hi;
        logic [HALF_W-1:0] key_lo;
    } sw_regs_t;

    typedef struct packed {
        logic done;
        logic pass;
    } cmd_result_t;

    function automatic logic [WORD_W-1:0] join_key(
        input logic [HALF_W-1:0] hi,
        input logic [HALF_W-1:0] lo
    );
        return {hi, lo};
    endfunction

    function automatic logic save_ok(
        input mode_t             mode,
        input logic              locked,
        input logic [WORD_W-1:0] stored,
        input logic [WORD_W-1:0] entered
    );
        logic mode_ok;
        logic key_ok;
        mode_ok = mode.keyen && !mode.keyblk;
        key_ok  = (stored == KEY_ERASED) || (stored == entered);
        return mode_ok && key_ok && !locked;
    endfunction

endpackage

// File: rtl/fg_regfile.sv
module fg_regfile
    import flash_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [WORD_W-1:0] reg_wdata,
    output sw_regs_t          regs
);

    sw_regs_t regs_q;
    reg_sel_e sel;

    assign sel  = reg_sel_e'(reg_sel);
    assign regs = regs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q.vmask  <= '1;
            regs_q.stage  <= '1;
            regs_q.mode   <= '0;
            regs_q.key_hi <= '0;
            regs_q.key_lo <= '0;
        end else if (reg_we) begin
            case (sel)
                SEL_VMASK: regs_q.vmask  <= reg_wdata;
                SEL_STAGE: regs_q.stage  <= reg_wdata;
                SEL_MODE: begin
                    regs_q.mode.keyen  <= reg_wdata[MODE_KEYEN_BIT];
                    regs_q.mode.keyblk <= reg_wdata[MODE_KEYBLK_BIT];
                end
                SEL_KEYHI: regs_q.key_hi <= reg_wdata[HALF_W-1:0];
                SEL_KEYLO: regs_q.key_lo <= reg_wdata[HALF_W-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/fg_keyvault.sv
module fg_keyvault
    import flash_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mass_erase,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_code,
    input  logic [WORD_W-1:0] stage,
    input  mode_t             mode,
    input  logic [HALF_W-1:0] key_hi,
    input  logic [HALF_W-1:0] key_lo,
    output logic [WORD_W-1:0] act_mask,
    output logic [WORD_W-1:0] key_stored,
    output logic              locked,
    output cmd_result_t       result
);

    // Persistent state: survives rst, cleared by mass_erase only.
    logic [WORD_W-1:0] key_q;
    logic [WORD_W-1:0] saved_q;
    logic [WORD_W-1:0] act_q;
    cmd_result_t       res_q;

    logic [WORD_W-1:0] entered;
    logic              is_save;
    logic              accept;

    assign entered = join_key(key_hi, key_lo);
    assign locked  = (key_q == KEY_PERMANENT);
    assign is_save = (cmd_code == CMD_SAVE);
    assign accept  = cmd_valid && is_save && save_ok(mode, locked, key_q, entered);

    always_ff @(posedge clk) begin
        if (mass_erase) begin
            key_q   <= KEY_ERASED;
            saved_q <= '1;
            act_q   <= '1;
        end else if (rst) begin
            act_q   <= saved_q;
        end else if (accept) begin
            saved_q <= stage;
            key_q   <= entered;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || mass_erase) begin
            res_q <= '0;
        end else begin
            res_q.done <= cmd_valid;
            res_q.pass <= accept;
        end
    end

    assign act_mask   = act_q;
    assign key_stored = key_q;
    assign result     = res_q;

endmodule

// File: rtl/fg_decide.sv
module fg_decide
    import flash_guard_pkg::*;
#(
    parameter int NUM_GROUPS      = NUM_GROUPS_DEF,
    parameter int PAGES_PER_GROUP = PAGES_GRP_DEF,
    parameter int PAGE_W          = 7
) (
    input  logic [WORD_W-1:0] act_mask,
    input  logic [WORD_W-1:0] vmask,
    input  logic [PAGE_W-1:0] query_page,
    input  logic              dbg_rd,
    output logic              wr_allow,
    output logic              rd_allow
);

    localparam int NUM_PAGES  = NUM_GROUPS * PAGES_PER_GROUP;
    localparam int TABLE_SIZE = 1 << PAGE_W;

    logic [WORD_W-1:0]     eff;
    logic [TABLE_SIZE-1:0] page_ok;

    assign eff = act_mask & vmask;

    for (genvar p = 0; p < TABLE_SIZE; p++) begin : g_page
        if (p < NUM_PAGES) begin : g_in
            assign page_ok[p] = eff[p / PAGES_PER_GROUP];
        end else begin : g_out
            assign page_ok[p] = 1'b0;
        end
    end

    assign wr_allow = page_ok[query_page];
    assign rd_allow = dbg_rd && eff[READ_BIT];

endmodule

// File: rtl/flash_guard.sv
module flash_guard
    import flash_guard_pkg::*;
#(
    parameter int NUM_GROUPS      = NUM_GROUPS_DEF,
    parameter int PAGES_PER_GROUP = PAGES_GRP_DEF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        mass_erase,
    input  logic        reg_we,
    input  logic [2:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    input  logic        cmd_valid,
    input  logic [7:0]  cmd_code,
    input  logic [6:0]  query_page,
    input  logic        dbg_rd,
    output logic        wr_allow,
    output logic        rd_allow,
    output logic        cmd_done,
    output logic        cmd_pass
);

    localparam int NUM_PAGES = NUM_GROUPS * PAGES_PER_GROUP;
    localparam int PAGE_W    = 7;

    sw_regs_t          sw_regs;
    mode_t             mode_w;
    logic [WORD_W-1:0] act_mask;
    logic [WORD_W-1:0] key_stored;
    logic              locked;
    cmd_result_t       result;

    fg_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .regs      (sw_regs)
    );

    assign mode_w = sw_regs.mode;

    fg_keyvault u_vault (
        .clk        (clk),
        .rst        (rst),
        .mass_erase (mass_erase),
        .cmd_valid  (cmd_valid),
        .cmd_code   (cmd_code),
        .stage      (sw_regs.stage),
        .mode       (mode_w),
        .key_hi     (sw_regs.key_hi),
        .key_lo     (sw_regs.key_lo),
        .act_mask   (act_mask),
        .key_stored (key_stored),
        .locked     (locked),
        .result     (result)
    );

    fg_decide #(
        .NUM_GROUPS      (NUM_GROUPS),
        .PAGES_PER_GROUP (PAGES_PER_GROUP),
        .PAGE_W          (PAGE_W)
    ) u_decide (
        .act_mask   (act_mask),
        .vmask      (sw_regs.vmask),
        .query_page (query_page),
        .dbg_rd     (dbg_rd),
        .wr_allow   (wr_allow),
        .rd_allow   (rd_allow)
    );

    assign cmd_done = result.done;
    assign cmd_pass = result.pass;

endmodule

// File: rtl/fg_chk.sv
module fg_chk
    import flash_guard_pkg::*;
#(
    parameter int PAGE_W    = 7,
    parameter int NUM_PAGES = 124
) (
    input logic              clk,
    input logic              rst,
    input logic              mass_erase,
    input logic              cmd_valid,
    input logic              cmd_done,
    input logic              cmd_pass,
    input logic              wr_allow,
    input logic [PAGE_W-1:0] query_page,
    input logic              locked,
    input mode_t             mode_w,
    input logic [WORD_W-1:0] act_mask,
    input logic [WORD_W-1:0] key_stored
);

    // R11
    done_after_cmd_chk: assert property (@(posedge clk) disable iff (rst || mass_erase)
        cmd_valid |=> cmd_done);

    // R11
    no_stray_done_chk: assert property (@(posedge clk) disable iff (rst || mass_erase)
        !cmd_valid |=> !cmd_done);

    // R9
    lock_refuses_chk: assert property (@(posedge clk) disable iff (rst || mass_erase)
        (cmd_valid && locked) |=> !cmd_pass);

    // R6
    mode_gate_chk: assert property (@(posedge clk) disable iff (rst || mass_erase)
        (cmd_valid && !(mode_w.keyen && !mode_w.keyblk)) |=> !cmd_pass);

    // R5
    active_holds_chk: assert property (@(posedge clk) disable iff (rst || mass_erase)
        1'b1 |=> $stable(act_mask));

    // R2
    range_guard_chk: assert property (@(posedge clk) disable iff (rst || mass_erase)
        wr_allow |-> (int'(query_page) < NUM_PAGES));

    // R10
    erase_clears_chk: assert property (@(posedge clk) disable iff (rst)
        $past(mass_erase) |-> (key_stored == KEY_ERASED && act_mask == '1));

endmodule

bind flash_guard fg_chk #(
    .PAGE_W    (PAGE_W),
    .NUM_PAGES (NUM_PAGES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mass_erase (mass_erase),
    .cmd_valid  (cmd_valid),
    .cmd_done   (cmd_done),
    .cmd_pass   (cmd_pass),
    .wr_allow   (wr_allow),
    .query_page (query_page),
    .locked     (locked),
    .mode_w     (mode_w),
    .act_mask   (act_mask),
    .key_stored (key_stored)
);

// File: tb/flash_guard_tb.sv
module flash_guard_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mass_erase = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_code = '0;
    logic [6:0]  query_page = '0;
    logic        dbg_rd = 1'b0;
    logic        wr_allow, rd_allow, cmd_done, cmd_pass;

    int n_tests = 0;
    int n_fail  = 0;
    bit exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    flash_guard u_dut (
        .clk(clk), .rst(rst), .mass_erase(mass_erase),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .query_page(query_page), .dbg_rd(dbg_rd),
        .wr_allow(wr_allow), .rd_allow(rd_allow),
        .cmd_done(cmd_done), .cmd_pass(cmd_pass)
    );

    // Monitor: pops expected command outcomes as results appear.
    always @(negedge clk) begin
        if (!rst && !mass_erase && cmd_done) begin
            n_tests++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R11 unexpected cmd_done: actual 1 expected 0");
            end else begin
                bit    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (cmd_pass !== e) begin
                    n_fail++;
                    $display("FAIL %s cmd_pass: actual %0b expected %0b", t, cmd_pass, e);
                end
            end
        end
    end

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic wr_reg(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic do_cmd(input logic [7:0] code, input bit exp_pass, input string tag);
        exp_q.push_back(exp_pass);
        tag_q.push_back(tag);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = code;
        @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic sys_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic do_erase();
        @(negedge clk); mass_erase = 1'b1;
        @(negedge clk); mass_erase = 1'b0;
    endtask

    task automatic set_key(input logic [15:0] hi, input logic [15:0] lo);
        wr_reg(3'd3, {16'h0, hi});
        wr_reg(3'd4, {16'h0, lo});
    endtask

    task automatic chk_page(input int page, input bit exp, input string tag);
        @(negedge clk);
        query_page = page[6:0];
        #1;
        n_tests++;
        if (wr_allow !== exp) begin
            n_fail++;
            $display("FAIL %s page %0d wr_allow: actual %0b expected %0b", tag, page, wr_allow, exp);
        end
    endtask

    task automatic chk_rd(input bit req, input bit exp, input string tag);
        @(negedge clk);
        dbg_rd = req;
        #1;
        n_tests++;
        if (rd_allow !== exp) begin
            n_fail++;
            $display("FAIL %s rd_allow: actual %0b expected %0b", tag, rd_allow, exp);
        end
        dbg_rd = 1'b0;
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        n_fail++;
        $display("FAIL watchdog expired: actual hung expected finished");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0; mass_erase = 1'b0;

        // R1 / R2: erased reset state, range edges
        for (int p = 0; p < 124; p += 41) chk_page(p, 1'b1, "R1");
        chk_page(123, 1'b1, "R2");
        chk_page(124, 1'b0, "R2");
        chk_page(127, 1'b0, "R2");
        chk_rd(1'b1, 1'b1, "R4");

        // R2 / R1: volatile word protects pages 4..7
        wr_reg(3'd0, 32'hFFFF_FFFD);
        chk_page(3, 1'b1, "R2");
        chk_page(4, 1'b0, "R2");
        chk_page(7, 1'b0, "R2");
        chk_page(8, 1'b1, "R2");
        sys_reset();
        chk_page(4, 1'b1, "R1");

        // R4: bit 31 guards debug reads
        wr_reg(3'd0, 32'h7FFF_FFFF);
        chk_rd(1'b1, 1'b0, "R4");
        chk_rd(1'b0, 1'b0, "R4");
        sys_reset();

        // R6 / R7 / R5: staging word protects pages 8..11
        wr_reg(3'd1, 32'hFFFF_FFFB);
        set_key(16'h1234, 16'h5678);
        wr_reg(3'd2, 32'h0000_0060);
        do_cmd(8'h0C, 1'b0, "R6");
        wr_reg(3'd2, 32'h0000_0008);
        do_cmd(8'h0C, 1'b0, "R6");
        wr_reg(3'd2, 32'h0000_0048);
        do_cmd(8'h0C, 1'b1, "R7");
        chk_page(8, 1'b1, "R5");
        sys_reset();
        chk_page(8, 1'b0, "R5");
        chk_page(11, 1'b0, "R5");
        chk_page(12, 1'b1, "R5");

        // R3: AND of volatile and persistent words
        wr_reg(3'd0, 32'hFFFF_FFFE);
        chk_page(0, 1'b0, "R3");
        chk_page(8, 1'b0, "R3");
        chk_page(5, 1'b1, "R3");

        // R8: key mismatch then match
        sys_reset();
        wr_reg(3'd1, 32'hFFFF_FFFF);
        wr_reg(3'd2, 32'h0000_0048);
        set_key(16'h1234, 16'h0000);
        do_cmd(8'h0C, 1'b0, "R8");
        sys_reset();
        chk_page(8, 1'b0, "R8");
        wr_reg(3'd1, 32'hFFFF_FFFF);
        wr_reg(3'd2, 32'h0000_0048);
        set_key(16'h1234, 16'h5678);
        do_cmd(8'h0C, 1'b1, "R8");
        sys_reset();
        chk_page(8, 1'b1, "R8");

        // R11: unknown command code
        wr_reg(3'd2, 32'h0000_0048);
        set_key(16'h1234, 16'h5678);
        do_cmd(8'h0D, 1'b0, "R11");

        // R10 / R7 / R9: erase, permanent key, retry
        do_erase();
        wr_reg(3'd1, 32'h7FFF_FFFF);
        wr_reg(3'd2, 32'h0000_0048);
        set_key(16'hDEAD, 16'hDEAD);
        do_cmd(8'h0C, 1'b1, "R7");
        sys_reset();
        chk_rd(1'b1, 1'b0, "R5");
        wr_reg(3'd1, 32'hFFFF_FFFF);
        wr_reg(3'd2, 32'h0000_0048);
        set_key(16'hDEAD, 16'hDEAD);
        do_cmd(8'h0C, 1'b0, "R9");
        sys_reset();
        chk_rd(1'b1, 1'b0, "R9");
        do_erase();
        chk_rd(1'b1, 1'b1, "R10");
        sys_reset();
        chk_rd(1'b1, 1'b1, "R10");
        wr_reg(3'd2, 32'h0000_0048);
        set_key(16'h0BAD, 16'hF00D);
        do_cmd(8'h0C, 1'b1, "R10");

        repeat (2) @(negedge clk);
        n_tests++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R11 missing results: actual %0d expected 0", exp_q.size());
        end
        report();
    end

endmodule